// File: doc/BRIEF.md
# Interrupt Distributor Register Block

This block collects interrupt requests from up to 64 sources and decides, for each of up to 8 processors, which enabled and pending source that processor should see next, with its priority. Software configures it through a 32-bit register bus with single-cycle requests and read data one clock later. The configuration covers a global forwarding switch, per-source enables reached through separate set and clear words, a per-source trigger mode, a per-source priority byte and a per-source byte of processor targets. A read-only word reports how many sources exist. A write-only port lets software raise one of the sixteen software interrupts (sources 0 to 15).

Peripheral inputs pass through a two-flop synchronizer. A source in edge mode latches pending on a rising edge and stays pending until claimed. A source in level mode is pending while its input is high and it is not active. A processor-side claim marks a source active. An end-of-service strobe clears the active mark. Sources 0 to 31 are local to a processor, and this build banks them for one processor only (processor 0).

Selection is done by a small state machine with three states:
- ST_OFF: forwarding is disabled and the published results are cleared.
- ST_SCAN: one source is visited per clock. For each processor, the best candidate seen so far is kept: a lower priority value wins, and a tie goes to the lower source number.
- ST_PUBLISH: the best candidates are copied to the outputs.

Its transitions are:
- OFF→SCAN when the global enable is set.
- SCAN→SCAN while the index is below the last source.
- SCAN→PUBLISH at the last source.
- PUBLISH→SCAN to start the next pass.
- SCAN→OFF or PUBLISH→OFF as soon as the global enable is cleared.

Top module: `irq_distributor`

## Requirements
- R1: Enable-set words sit at 0x100+4w and enable-clear words at 0x180+4w, with source n in word n/32, bit n%32. Writing 1 to a bit of a set word enables that source, and writing 1 to a bit of a clear word disables it. Writing 0 to any bit changes nothing. Reading either word returns the current enables.
- R2: Trigger-mode words sit at 0xC00+4*(n/16). Bit 2*(n%16)+1 of the word is 1 for rising-edge mode and 0 for level mode. Bit 2*(n%16) always reads 0. After reset, every source whose mode can be written is in level mode.
- R3: Sources 0 to 15 always read trigger mode 2'b10 (edge), and writes to their mode bits are ignored. Sources 0 to 31 always read a target byte of 0x01 (processor 0), and writes to those target bytes are ignored.
- R4: Priority bytes sit at 0xC00-independent words 0x400+4*(n/4), with source n in byte n%4 (bits 8*(n%4)+7 down to 8*(n%4)). Among the candidates for a processor, the lowest value wins. On equal values, the lowest source number wins.
- R5: Target bytes sit at 0x800+4*(n/4), with source n in byte n%4. Bit k of a target byte lets source n be forwarded to processor k.
- R6: Bit 0 of the control word at 0x000 enables forwarding, and its reset value is 0. While it is 0, every bit of fwd_valid is 0, starting from the cycle after the write that clears it.
- R7: The type word at 0x004 is read-only. Its bits [4:0] hold NUM_SRC/32-1 (1 for 64 sources), capped for 1020 sources, and its other bits read 0.
- R8: A write to 0xF00 with bit 16 set makes software source wdata[3:0] pending. Bits 17 to 23 select processors that have no bank in this build, so a write with bit 16 clear pends nothing.
- R9: A source in edge mode becomes pending on a rising edge of its synchronized input. It stays pending after the input falls, until it is claimed. Pending words read at 0x200+4w, with the same bit layout as the enables.
- R10: A source in level mode is pending while its synchronized input is high and it is not active. claim_valid with claim_id marks the source active. eoi_valid with eoi_id clears the active mark.
- R11: Read data appears on bus_rdata in the cycle after the request. Unmapped or misaligned addresses read as 0, and so does any word index beyond the number of sources.
- R12: A source is a candidate for processor k when it is enabled, pending, not active and targets processor k. Within two scan passes of a change, fwd_valid[k], fwd_id and fwd_prio for processor k report the winning candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_in | input | NUM_SRC | Peripheral request lines (bits 0 to 15 are unused) |
| claim_valid | input | 1 | Processor takes a source into service |
| claim_id | input | 6 | Source being claimed |
| eoi_valid | input | 1 | Processor finishes service of a source |
| eoi_id | input | 6 | Source whose service ends |
| fwd_valid | output | NUM_CPU | Per-processor forward request |
| fwd_id | output | NUM_CPU*6 | Per-processor winning source, processor k at bits [6k+5:6k] |
| fwd_prio | output | NUM_CPU*8 | Per-processor winning priority, processor k at bits [8k+7:8k] |

## Verification
The hardest situation to reach from the ports is a change in the winner while one candidate is active, for example a tie that flips to the other source when the lower-numbered one is claimed and flips back at end of service. The stimulus reaches it by holding two level inputs high on the same target. It then rewrites their shared priority word, first to give the higher-numbered source the lower value and then to make the two values equal. The claim and end-of-service strobes are issued after that. Edge latching is checked by pulsing an input briefly and reading the pending word after the input has fallen. The software port is checked once with the processor-0 bit set and once with only the other processor bits set.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int ADDR_W    = 12;
    localparam int PRIO_W    = 8;
    localparam int TGT_W     = 8;
    localparam int SGI_COUNT = 16;
    localparam int LOCAL_SRC = 32;
    localparam int SRC_LIMIT = 1020;

    localparam logic [ADDR_W-1:0] A_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] A_TYPE = 12'h004;
    localparam logic [ADDR_W-1:0] A_SWI  = 12'hF00;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_SCAN    = 2'd1,
        ST_PUBLISH = 2'd2
    } arb_state_t;
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_SRC-1:0]        pend_i,
    output logic                      gen_en_o,
    output logic [NUM_SRC-1:0]        en_o,
    output logic [NUM_SRC-1:0]        edge_o,
    output logic [NUM_SRC*PRIO_W-1:0] prio_o,
    output logic [NUM_SRC*TGT_W-1:0]  tgt_o,
    output logic [SGI_COUNT-1:0]      swi_set_o
);
    localparam int EN_WORDS   = NUM_SRC / 32;
    localparam int BYTE_WORDS = NUM_SRC / 4;
    localparam int CFG_WORDS  = NUM_SRC / 16;
    localparam int CAPPED     = (NUM_SRC > SRC_LIMIT) ? SRC_LIMIT : NUM_SRC;
    localparam logic [4:0] TYPE_N = 5'(CAPPED / 32 - 1);

    logic        gen_en_q;
    logic [NUM_SRC-1:0] en_q, edge_q;
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    logic [NUM_SRC*TGT_W-1:0]  tgt_q;
    logic [31:0] rd_val;
    logic [NUM_SRC-1:0] set_mask, clr_mask;

    int unsigned wlo, whi;
    logic aligned, wr, rd;
    logic sel_ctrl, sel_type, sel_swi, sel_enset, sel_enclr, sel_pend;
    logic sel_prio, sel_tgt, sel_cfg, hit_any;

    assign wlo     = 32'(bus_addr[6:2]);
    assign whi     = 32'(bus_addr[7:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr      = bus_valid && bus_write;
    assign rd      = bus_valid && !bus_write;

    assign sel_ctrl  = (bus_addr == A_CTRL);
    assign sel_type  = (bus_addr == A_TYPE);
    assign sel_swi   = (bus_addr == A_SWI);
    assign sel_enset = aligned && (bus_addr[11:7] == 5'h02) && (wlo < EN_WORDS);
    assign sel_enclr = aligned && (bus_addr[11:7] == 5'h03) && (wlo < EN_WORDS);
    assign sel_pend  = aligned && (bus_addr[11:7] == 5'h04) && (wlo < EN_WORDS);
    assign sel_prio  = aligned && (bus_addr[11:8] == 4'h4) && (whi < BYTE_WORDS);
    assign sel_tgt   = aligned && (bus_addr[11:8] == 4'h8) && (whi < BYTE_WORDS);
    assign sel_cfg   = aligned && (bus_addr[11:8] == 4'hC) && (whi < CFG_WORDS);
    assign hit_any   = sel_ctrl | sel_type | sel_enset | sel_enclr | sel_pend |
                       sel_prio | sel_tgt | sel_cfg;

    // Per-source set and clear strobes from the enable words
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (wr && sel_enset && (wlo == n / 32) && bus_wdata[n % 32]) set_mask[n] = 1'b1;
            if (wr && sel_enclr && (wlo == n / 32) && bus_wdata[n % 32]) clr_mask[n] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_en_q <= 1'b0;
            en_q     <= '0;
            prio_q   <= '0;
            for (int n = 0; n < NUM_SRC; n++) begin
                edge_q[n]            <= (n < SGI_COUNT);
                tgt_q[n*TGT_W +: TGT_W] <= (n < LOCAL_SRC) ? 8'h01 : 8'h00;
            end
        end else begin
            en_q <= (en_q | set_mask) & ~clr_mask;
            if (wr && sel_ctrl) gen_en_q <= bus_wdata[0];
            for (int n = 0; n < NUM_SRC; n++) begin
                if (wr && sel_prio && (whi == n / 4))
                    prio_q[n*PRIO_W +: PRIO_W] <= bus_wdata[(n % 4)*8 +: 8];
                if (wr && sel_tgt && (whi == n / 4) && (n >= LOCAL_SRC))
                    tgt_q[n*TGT_W +: TGT_W] <= bus_wdata[(n % 4)*8 +: 8];
                if (wr && sel_cfg && (whi == n / 16) && (n >= SGI_COUNT))
                    edge_q[n] <= bus_wdata[(n % 16)*2 + 1];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (sel_ctrl) rd_val[0] = gen_en_q;
        if (sel_type) rd_val[4:0] = TYPE_N;
        for (int n = 0; n < NUM_SRC; n++) begin
            if ((sel_enset || sel_enclr) && (wlo == n / 32)) rd_val[n % 32] = en_q[n];
            if (sel_pend && (wlo == n / 32)) rd_val[n % 32] = pend_i[n];
            if (sel_prio && (whi == n / 4)) rd_val[(n % 4)*8 +: 8] = prio_q[n*PRIO_W +: PRIO_W];
            if (sel_tgt && (whi == n / 4)) rd_val[(n % 4)*8 +: 8] = tgt_q[n*TGT_W +: TGT_W];
            if (sel_cfg && (whi == n / 16)) rd_val[(n % 16)*2 + 1] = edge_q[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd ? rd_val : 32'h0;
    end

    assign swi_set_o = (wr && sel_swi && bus_wdata[16]) ?
                       (SGI_COUNT'(1) << bus_wdata[3:0]) : '0;

    assign gen_en_o = gen_en_q;
    assign en_o     = en_q;
    assign edge_o   = edge_q;
    assign prio_o   = prio_q;
    assign tgt_o    = tgt_q;

    // R1
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0 && clr_mask == '0) |=> ((en_q & $past(set_mask)) == $past(set_mask)));
    // R1
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((en_q & $past(clr_mask)) == '0));
    // R11
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !hit_any) |=> (bus_rdata == 32'h0));
endmodule

// File: rtl/irqd_pending.sv
module irqd_pending
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_in,
    input  logic [NUM_SRC-1:0]   edge_i,
    input  logic [SGI_COUNT-1:0] swi_set_i,
    input  logic                 claim_valid,
    input  logic [ID_W-1:0]      claim_id,
    input  logic                 eoi_valid,
    input  logic [ID_W-1:0]      eoi_id,
    output logic [NUM_SRC-1:0]   pend_o,
    output logic [NUM_SRC-1:0]   active_o
);
    localparam logic [NUM_SRC-1:0] ONE      = NUM_SRC'(1);
    localparam logic [NUM_SRC-1:0] PERIPH_M = ~NUM_SRC'({SGI_COUNT{1'b1}});

    logic [NUM_SRC-1:0] sync1_q, sync2_q, edge_pend_q, active_q;
    logic [NUM_SRC-1:0] rise, claim_mask, eoi_mask, swi_wide;

    assign rise       = sync1_q & ~sync2_q & PERIPH_M;
    assign claim_mask = claim_valid ? (ONE << claim_id) : '0;
    assign eoi_mask   = eoi_valid ? (ONE << eoi_id) : '0;
    assign swi_wide   = NUM_SRC'(swi_set_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q     <= '0;
            sync2_q     <= '0;
            edge_pend_q <= '0;
            active_q    <= '0;
        end else begin
            sync1_q     <= irq_in;
            sync2_q     <= sync1_q;
            edge_pend_q <= (edge_pend_q & ~claim_mask) | (rise & edge_i) | swi_wide;
            active_q    <= (active_q | claim_mask) & ~eoi_mask;
        end
    end

    always_comb begin
        for (int n = 0; n < NUM_SRC; n++)
            pend_o[n] = edge_i[n] ? edge_pend_q[n] : (sync2_q[n] & ~active_q[n]);
    end
    assign active_o = active_q;

    // R10
    claim_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_valid && !(eoi_valid && eoi_id == claim_id)) |=> ((active_q & $past(claim_mask)) != '0));
    // R10
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |=> ((active_q & $past(eoi_mask)) == '0));
    // R9
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((edge_pend_q & $past(edge_pend_q & ~claim_mask)) == $past(edge_pend_q & ~claim_mask)));
endmodule

// File: rtl/irqd_arbiter.sv
module irqd_arbiter
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 8,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      gen_en_i,
    input  logic [NUM_SRC-1:0]        cand_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [NUM_SRC*TGT_W-1:0]  tgt_i,
    output logic [NUM_CPU-1:0]        fwd_valid,
    output logic [NUM_CPU*ID_W-1:0]   fwd_id,
    output logic [NUM_CPU*PRIO_W-1:0] fwd_prio
);
    localparam logic [ID_W-1:0] LAST = ID_W'(NUM_SRC - 1);

    arb_state_t state_q, state_d;
    logic [ID_W-1:0]   idx_q;
    logic [NUM_CPU-1:0] hit_q, pub_valid_q;
    logic [ID_W-1:0]   best_id_q   [NUM_CPU];
    logic [PRIO_W-1:0] best_prio_q [NUM_CPU];
    logic [ID_W-1:0]   pub_id_q    [NUM_CPU];
    logic [PRIO_W-1:0] pub_prio_q  [NUM_CPU];
    logic [PRIO_W-1:0] cur_prio;
    logic [TGT_W-1:0]  cur_tgt;
    logic              cur_cand;

    assign cur_prio = prio_i[idx_q*PRIO_W +: PRIO_W];
    assign cur_tgt  = tgt_i[idx_q*TGT_W +: TGT_W];
    assign cur_cand = cand_i[idx_q];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (gen_en_i) state_d = ST_SCAN;
            ST_SCAN:    if (!gen_en_i) state_d = ST_OFF;
                        else if (idx_q == LAST) state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = gen_en_i ? ST_SCAN : ST_OFF;
            default:    state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            hit_q       <= '0;
            pub_valid_q <= '0;
            for (int k = 0; k < NUM_CPU; k++) begin
                best_id_q[k]   <= '0;
                best_prio_q[k] <= '0;
                pub_id_q[k]    <= '0;
                pub_prio_q[k]  <= '0;
            end
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    idx_q       <= '0;
                    hit_q       <= '0;
                    pub_valid_q <= '0;
                end
                ST_SCAN: begin
                    idx_q <= idx_q + 1'b1;
                    for (int k = 0; k < NUM_CPU; k++) begin
                        if (cur_cand && cur_tgt[k] && (!hit_q[k] || cur_prio < best_prio_q[k])) begin
                            hit_q[k]       <= 1'b1;
                            best_id_q[k]   <= idx_q;
                            best_prio_q[k] <= cur_prio;
                        end
                    end
                end
                ST_PUBLISH: begin
                    idx_q       <= '0;
                    hit_q       <= '0;
                    pub_valid_q <= hit_q;
                    for (int k = 0; k < NUM_CPU; k++) begin
                        pub_id_q[k]   <= best_id_q[k];
                        pub_prio_q[k] <= best_prio_q[k];
                    end
                end
                default: idx_q <= '0;
            endcase
        end
    end

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_out
        assign fwd_valid[k]                  = pub_valid_q[k] & gen_en_i;
        assign fwd_id[k*ID_W +: ID_W]        = pub_id_q[k];
        assign fwd_prio[k*PRIO_W +: PRIO_W]  = pub_prio_q[k];
    end

    // R12
    scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && idx_q == LAST && gen_en_i) |=> (state_q == ST_PUBLISH));
    // R12
    publish_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PUBLISH) |=> (state_q != ST_PUBLISH));
    // R12
    pub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && $past(state_q) == ST_SCAN) |-> $stable(pub_valid_q));
    // R6
    off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && $past(state_q) == ST_OFF) |-> (pub_valid_q == '0));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 8,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_SRC-1:0]        irq_in,
    input  logic                      claim_valid,
    input  logic [ID_W-1:0]           claim_id,
    input  logic                      eoi_valid,
    input  logic [ID_W-1:0]           eoi_id,
    output logic [NUM_CPU-1:0]        fwd_valid,
    output logic [NUM_CPU*ID_W-1:0]   fwd_id,
    output logic [NUM_CPU*PRIO_W-1:0] fwd_prio
);
    logic                      gen_en;
    logic [NUM_SRC-1:0]        en, edge_mode, pend, active, cand;
    logic [NUM_SRC*PRIO_W-1:0] prio;
    logic [NUM_SRC*TGT_W-1:0]  tgt;
    logic [SGI_COUNT-1:0]      swi_set;

    irqd_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend_i(pend), .gen_en_o(gen_en), .en_o(en), .edge_o(edge_mode),
        .prio_o(prio), .tgt_o(tgt), .swi_set_o(swi_set)
    );

    irqd_pending #(.NUM_SRC(NUM_SRC)) u_pending (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_i(edge_mode),
        .swi_set_i(swi_set), .claim_valid(claim_valid), .claim_id(claim_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .pend_o(pend), .active_o(active)
    );

    assign cand = en & pend & ~active;

    irqd_arbiter #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_arbiter (
        .clk(clk), .rst_n(rst_n), .gen_en_i(gen_en), .cand_i(cand),
        .prio_i(prio), .tgt_i(tgt),
        .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio)
    );
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
    localparam int NUM_SRC = 64;
    localparam int NUM_CPU = 8;
    localparam int ID_W    = 6;
    localparam int SETTLE  = 3 * NUM_SRC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NUM_SRC-1:0] irq_in = '0;
    logic claim_valid = 1'b0, eoi_valid = 1'b0;
    logic [ID_W-1:0] claim_id = '0, eoi_id = '0;
    logic [NUM_CPU-1:0] fwd_valid;
    logic [NUM_CPU*ID_W-1:0] fwd_id;
    logic [NUM_CPU*8-1:0] fwd_prio;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_distributor #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .claim_valid(claim_valid), .claim_id(claim_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id),
        .fwd_valid(fwd_valid), .fwd_id(fwd_id), .fwd_prio(fwd_prio)
    );

    typedef struct packed {
        logic        do_wr;
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h100, 32'h0000_00F0, 12'h100, 32'h0000_00F0, 4'd1},  // R1 set
        '{1'b1, 12'h100, 32'h0000_0000, 12'h180, 32'h0000_00F0, 4'd1},  // R1 zero write, clear word reads same
        '{1'b1, 12'h180, 32'h0000_0030, 12'h100, 32'h0000_00C0, 4'd1},  // R1 clear
        '{1'b1, 12'h104, 32'h8000_0001, 12'h104, 32'h8000_0001, 4'd1},  // R1 sources 32 and 63
        '{1'b1, 12'h400, 32'h1122_3344, 12'h400, 32'h1122_3344, 4'd4},  // R4
        '{1'b1, 12'h40C, 32'hA0B0_C0D0, 12'h40C, 32'hA0B0_C0D0, 4'd4},  // R4
        '{1'b1, 12'h800, 32'hFFFF_FFFF, 12'h800, 32'h0101_0101, 4'd3},  // R3 local targets fixed
        '{1'b1, 12'h820, 32'h8040_2010, 12'h820, 32'h8040_2010, 4'd5},  // R5
        '{1'b1, 12'hC00, 32'h0000_0000, 12'hC00, 32'hAAAA_AAAA, 4'd3},  // R3 software modes fixed
        '{1'b1, 12'hC04, 32'hFFFF_FFFF, 12'hC04, 32'hAAAA_AAAA, 4'd2},  // R2 low bit reads 0
        '{1'b1, 12'hC04, 32'h0000_0000, 12'hC04, 32'h0000_0000, 4'd2},  // R2 back to level
        '{1'b1, 12'h004, 32'hFFFF_FFFF, 12'h004, 32'h0000_0001, 4'd7},  // R7 read-only
        '{1'b0, 12'h000, 32'h0000_0000, 12'h300, 32'h0000_0000, 4'd11}, // R11 unmapped
        '{1'b0, 12'h000, 32'h0000_0000, 12'h108, 32'h0000_0000, 4'd11}, // R11 word beyond sources
        '{1'b1, 12'h000, 32'h0000_0001, 12'h000, 32'h0000_0001, 4'd6}   // R6 control readback
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic claim(input logic [ID_W-1:0] id);
        @(negedge clk);
        claim_valid = 1'b1; claim_id = id;
        @(negedge clk);
        claim_valid = 1'b0;
    endtask

    task automatic eoi(input logic [ID_W-1:0] id);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_id = id;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog (all R) actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R6 fwd_valid after reset", 32'(fwd_valid), 32'h0);
        bus_rd(12'h000, rv); chk("R6 control reset", rv, 32'h0);
        bus_rd(12'h004, rv); chk("R7 type word", rv, 32'h1);
        bus_rd(12'h100, rv); chk("R1 enables reset", rv, 32'h0);
        bus_rd(12'hC04, rv); chk("R2 mode reset level", rv, 32'h0);

        // Register table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].do_wr) bus_wr(VECS[i].waddr, VECS[i].wdata);
            bus_rd(VECS[i].raddr, rv);
            chk($sformatf("R%0d table row %0d", VECS[i].req, i), rv, VECS[i].exp);
        end

        // Clean up the table state
        bus_wr(12'h000, 32'h0);
        bus_wr(12'h180, 32'hFFFF_FFFF);
        bus_wr(12'h184, 32'hFFFF_FFFF);

        // Forwarding with global enable off, then on (R6, R12)
        bus_wr(12'h428, 32'h0000_2080);      // src40=0x80, src41=0x20
        bus_wr(12'h828, 32'h0000_0404);      // src40, src41 -> processor 2
        bus_wr(12'h104, 32'h0000_0100);      // enable src40
        irq_in[40] = 1'b1;
        irq_in[41] = 1'b1;
        settle();
        chk("R6 no forward while disabled", 32'(fwd_valid), 32'h0);
        bus_wr(12'h000, 32'h1);
        settle();
        chk("R12 cpu2 valid", 32'(fwd_valid), 32'h04);
        chk("R12 cpu2 id src40", 32'(fwd_id[2*ID_W +: ID_W]), 32'd40);
        chk("R5 cpu2 prio", 32'(fwd_prio[2*8 +: 8]), 32'h80);

        // Priority ordering (R4)
        bus_wr(12'h104, 32'h0000_0200);      // enable src41
        settle();
        chk("R4 lower value wins", 32'(fwd_id[2*ID_W +: ID_W]), 32'd41);
        chk("R4 winning prio", 32'(fwd_prio[2*8 +: 8]), 32'h20);
        bus_wr(12'h428, 32'h0000_2020);
        settle();
        chk("R4 tie lower id", 32'(fwd_id[2*ID_W +: ID_W]), 32'd40);

        // Level claim and end of service (R10)
        claim(6'd40);
        settle();
        chk("R10 claimed excluded", 32'(fwd_id[2*ID_W +: ID_W]), 32'd41);
        bus_rd(12'h204, rv); chk("R10 level pending masked when active", rv, 32'h0000_0200);
        eoi(6'd40);
        settle();
        chk("R10 after eoi", 32'(fwd_id[2*ID_W +: ID_W]), 32'd40);
        irq_in[40] = 1'b0;
        repeat (4) @(negedge clk);
        bus_rd(12'h204, rv); chk("R10 level drops with input", rv, 32'h0000_0200);

        // Edge latch (R9)
        bus_wr(12'hC0C, 32'h0000_0020);      // src50 edge mode
        irq_in[50] = 1'b1;
        repeat (3) @(negedge clk);
        irq_in[50] = 1'b0;
        repeat (6) @(negedge clk);
        bus_rd(12'h204, rv); chk("R9 edge held after fall", rv, 32'h0004_0200);
        claim(6'd50);
        bus_rd(12'h204, rv); chk("R9 claim clears edge", rv, 32'h0000_0200);
        eoi(6'd50);
        irq_in[41] = 1'b0;

        // Software port (R8)
        bus_wr(12'hF00, 32'h0001_0005);
        bus_rd(12'h200, rv); chk("R8 processor0 bit pends", rv, 32'h0000_0020);
        bus_wr(12'hF00, 32'h00FE_0007);
        bus_rd(12'h200, rv); chk("R8 other processors ignored", rv, 32'h0000_0020);
        bus_wr(12'h100, 32'h0000_0020);
        settle();
        chk("R12 software source to cpu0", 32'(fwd_valid), 32'h01);
        chk("R12 cpu0 id", 32'(fwd_id[0 +: ID_W]), 32'd5);
        chk("R3 cpu0 prio", 32'(fwd_prio[0 +: 8]), 32'h00);

        // Immediate cut-off (R6)
        bus_wr(12'h000, 32'h0);
        chk("R6 cut-off next cycle", 32'(fwd_valid), 32'h0);

        summary();
        $finish;
    end
endmodule